// File: doc/BRIEF.md
# Region Cache-Mode Demotion Guard

This block holds the caching policy of every memory region that a cache controller serves. There are three policies: write-back, write-through and non-cacheable. The block decides whether a requested policy change may go ahead, and it enforces one rule: a region's policy can only move downward in that order. Every region starts at write-back when reset is applied. Reset is the only way to bring a region back to a higher policy.

A change is never applied straight away. When a request is legal, the block asks an external maintenance engine to clear the whole cache, so that dirty lines are written back and every line is invalidated. It holds that request until the engine reports that it is done. The new policy appears on the region's output in the cycle after the done pulse, together with a success response. A request is refused with an error if it is malformed or would not lower the policy. A request that comes in while a clear is still open is answered busy. Mapping addresses to regions is the job of surrounding logic.

Top module: `region_mode_guard`

## Requirements
- R1: After reset every region reports write-back (2'b10), `clr_req` is low and `rsp_valid` is low.
- R2: Policy codes are 2'b00 non-cacheable, 2'b01 write-through and 2'b10 write-back, ranked in that ascending order. A request whose policy is equal to or above the region's current policy gets an error response (`rsp_status` 2'b10) in the cycle after it is sampled. No clear is started and no region changes.
- R3: A request with policy code 2'b11, or with a region index of `NUM_REGIONS` or more, gets the error response one cycle later and has no effect.
- R4: A request that lowers the policy is not answered at once. `clr_req` rises in the next cycle and stays high until `clr_done` is seen, and the region keeps its old policy for that whole time.
- R5: In the cycle after `clr_done` is sampled with `clr_req` high, `rsp_valid` is high with success (2'b00), the region's output shows the new policy, and `clr_req` is low.
- R6: A request sampled while a clear is open and `clr_done` is low gets a busy response (2'b01) in the next cycle and changes nothing.
- R7: A request sampled in the same cycle as `clr_done` is answered busy one cycle after the success response. It changes nothing, and the port is idle afterwards if no further request arrives.
- R8: A region can be lowered step by step from write-back to write-through to non-cacheable. Any attempt to raise it is refused, and reset restores write-back.
- R9: A change affects only the addressed region. Every other region's output stays the same.
- R10: A `clr_done` pulse while no clear is open produces no response and no policy change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Change request strobe |
| req_region | input | IDX_W | Index of the region to change |
| req_mode | input | 2 | Requested policy code |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 00 success, 01 busy, 10 error |
| clr_req | output | 1 | Whole-cache clear request to the maintenance engine |
| clr_done | input | 1 | One-cycle completion pulse from the maintenance engine |
| region_modes | output | 2*NUM_REGIONS | Current policy of each region, region i at bits 2i+1:2i |

## Verification
The stimulus covers three kinds of request.

- **Downward steps through all three policies.** These show that a legal lowering is held back until the clear completes. They also show that only the addressed region moves.
- **Equal, upward, reserved-code and out-of-range requests.** These separate the error path from acceptance.
- **Requests timed against an open clear.** One arrives while the clear is pending and one arrives in the cycle of the done pulse. Together they show busy handling before and at completion, and the ordering of the deferred busy reply after the success reply.

A stray done pulse and a final reset confirm that nothing can raise a policy except reset.

// File: rtl/region_mode_guard.sv
module region_mode_guard #(
  parameter int NUM_REGIONS = 5,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [IDX_W-1:0]         req_region,
  input  logic [1:0]               req_mode,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_status,
  output logic                     clr_req,
  input  logic                     clr_done,
  output logic [2*NUM_REGIONS-1:0] region_modes
);

  localparam logic [1:0] M_WB   = 2'b10;
  localparam logic [1:0] S_OK   = 2'b00;
  localparam logic [1:0] S_BUSY = 2'b01;
  localparam logic [1:0] S_ERR  = 2'b10;

  logic             pend, hold;
  logic [IDX_W-1:0] tgt_region;
  logic [1:0]       tgt_mode;
  logic [1:0]       mode_q [NUM_REGIONS];
  logic [1:0]       cur_mode;
  logic             in_range, refuse, finish;

  assign in_range = 32'(req_region) < NUM_REGIONS;
  assign finish   = pend & clr_done;
  assign clr_req  = pend;

  always_comb begin
    cur_mode = 2'b00;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (req_region == IDX_W'(i)) cur_mode = mode_q[i];
  end

  assign refuse = !in_range || (req_mode == 2'b11) || (req_mode >= cur_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      hold       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= S_OK;
      tgt_region <= '0;
      tgt_mode   <= M_WB;
    end else begin
      rsp_valid <= 1'b0;
      if (finish) begin
        pend       <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_status <= S_OK;
        hold       <= req_valid;
      end else if (hold) begin
        rsp_valid  <= 1'b1;
        rsp_status <= S_BUSY;
        hold       <= req_valid;
      end else if (req_valid) begin
        if (pend) begin
          rsp_valid  <= 1'b1;
          rsp_status <= S_BUSY;
        end else if (refuse) begin
          rsp_valid  <= 1'b1;
          rsp_status <= S_ERR;
        end else begin
          pend       <= 1'b1;
          tgt_region <= req_region;
          tgt_mode   <= req_mode;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[i] <= M_WB;
      else if (finish && tgt_region == IDX_W'(i)) mode_q[i] <= tgt_mode;
    end
    assign region_modes[2*i +: 2] = mode_q[i];

    // R8: a policy never moves upward while out of reset
    p_no_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> mode_q[i] <= $past(mode_q[i]));
    // R4/R5: a policy moves only right after a completed clear
    p_change_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] != $past(mode_q[i])) |-> $past(clr_done && clr_req));
  end

  p_status_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b11);
  p_err_no_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == S_ERR) |-> !clr_req);
  p_ok_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == S_OK) |-> $past(clr_done && clr_req));
  p_clr_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_req) |-> $past(req_valid));
  p_clr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !clr_done) |=> clr_req);

endmodule

// File: tb/region_mode_guard_tb.sv
module region_mode_guard_tb;
  localparam int NR = 5;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [IW-1:0] req_region = '0;
  logic [1:0] req_mode = '0;
  logic clr_done = 1'b0;
  logic rsp_valid, clr_req;
  logic [1:0] rsp_status;
  logic [2*NR-1:0] region_modes;

  logic [1:0] em [NR];
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  region_mode_guard #(.NUM_REGIONS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
    .req_mode(req_mode), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .clr_req(clr_req), .clr_done(clr_done), .region_modes(region_modes));

  function automatic logic [2*NR-1:0] exp_vec();
    logic [2*NR-1:0] v;
    for (int i = 0; i < NR; i++) v[2*i +: 2] = em[i];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NR; i++) em[i] = 2'b10;
    @(negedge clk);
  endtask

  task automatic issue(int r, logic [1:0] m);
    req_valid = 1'b1; req_region = IW'(r); req_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 modes", 32'(region_modes), 32'(exp_vec()));
    chk("R1 clr_req", 32'(clr_req), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic expect_err(int r, logic [1:0] m, string tag);
    issue(r, m);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 1);
    chk({tag, " status"}, 32'(rsp_status), 32'h2);
    chk({tag, " no clear"}, 32'(clr_req), 0);
    chk({tag, " R9 modes"}, 32'(region_modes), 32'(exp_vec()));
  endtask

  task automatic demote_ok(int r, logic [1:0] m, string tag);
    issue(r, m);
    chk({tag, " R4 no rsp"}, 32'(rsp_valid), 0);
    chk({tag, " R4 clr_req"}, 32'(clr_req), 1);
    repeat (2) begin
      @(negedge clk);
      chk({tag, " R4 clr held"}, 32'(clr_req), 1);
      chk({tag, " R4 mode kept"}, 32'(region_modes), 32'(exp_vec()));
    end
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    em[r] = m;
    chk({tag, " R5 rsp_valid"}, 32'(rsp_valid), 1);
    chk({tag, " R5 status"}, 32'(rsp_status), 0);
    chk({tag, " R5 R9 modes"}, 32'(region_modes), 32'(exp_vec()));
    chk({tag, " R5 clr drop"}, 32'(clr_req), 0);
  endtask

  task automatic t_refusals();
    expect_err(0, 2'b10, "R2 equal");
    expect_err(0, 2'b11, "R3 code3");
    expect_err(6, 2'b00, "R3 range");
  endtask

  task automatic t_stepdown();
    demote_ok(1, 2'b01, "R8 wb-wt");
    expect_err(1, 2'b10, "R8 raise");
    demote_ok(1, 2'b00, "R8 wt-nc");
    expect_err(1, 2'b01, "R8 nc-wt");
    expect_err(1, 2'b00, "R2 nc-nc");
  endtask

  task automatic t_busy();
    issue(2, 2'b00);
    chk("R4 accept", 32'(clr_req), 1);
    issue(3, 2'b01);
    chk("R6 busy valid", 32'(rsp_valid), 1);
    chk("R6 busy status", 32'(rsp_status), 1);
    chk("R6 modes", 32'(region_modes), 32'(exp_vec()));
    chk("R6 clr held", 32'(clr_req), 1);
    clr_done = 1'b1;
    req_valid = 1'b1; req_region = 3'd4; req_mode = 2'b00;
    @(negedge clk);
    clr_done = 1'b0; req_valid = 1'b0;
    em[2] = 2'b00;
    chk("R5 ok first", 32'(rsp_status), 0);
    chk("R5 ok valid", 32'(rsp_valid), 1);
    @(negedge clk);
    chk("R7 busy valid", 32'(rsp_valid), 1);
    chk("R7 busy status", 32'(rsp_status), 1);
    chk("R7 modes", 32'(region_modes), 32'(exp_vec()));
    @(negedge clk);
    chk("R7 idle", 32'(rsp_valid), 0);
    chk("R7 no clear", 32'(clr_req), 0);
  endtask

  task automatic t_stray_done();
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk("R10 no rsp", 32'(rsp_valid), 0);
    chk("R10 modes", 32'(region_modes), 32'(exp_vec()));
    @(negedge clk);
    chk("R10 clr low", 32'(clr_req), 0);
    demote_ok(4, 2'b01, "R10 after");
  endtask

  task automatic t_restore();
    do_reset();
    chk("R8 reset restores", 32'(region_modes), 32'h2AA);
    chk("R1 rsp idle", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_refusals();
    t_stepdown();
    t_busy();
    t_stray_done();
    t_restore();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule